// File: doc/BRIEF.md
# Fractional Clock Divider

This block derives a slower clock from a fast reference clock. The division ratio is a + b/c, where a is an integer part, b is a numerator and c is a denominator. At each output period boundary, an accumulator adds b to a running remainder. When the sum reaches c, that period lasts a + 1 reference cycles. Otherwise it lasts a cycles. Over any c consecutive periods, exactly b periods are stretched, so the long-term average ratio is exact. An integer-only mode ignores the fraction completely. That mode accepts only even ratios of six or more.

The block has two outputs. `tick` is a one-cycle clock-enable pulse that marks the first reference cycle of every output period. `clk_out` is a square wave that is high for the first half of each period. New settings are presented on the configuration inputs and captured with a `load` strobe. They are checked for legality and held in a pending register. They take effect at the next period boundary, so a change never shortens a period that is already running. An illegal setting raises `cfg_err` and is discarded. A 7-bit start offset, sampled during reset, delays the first output period after reset.

Top module: `fdiv_top`

## Requirements
- R1: While reset is held and on release with `phase_ofs` = 0, `tick` = 1, `clk_out` = 1 and `cfg_err` = 0. The default setting is integer mode with a ratio of 8, so the first period lasts 8 cycles.
- R2: When `phase_ofs` = k during reset, `tick` and `clk_out` stay low for exactly k reference cycles after reset is released, and then the first period starts.
- R3: In fractional mode (`int_mode` = 0), every period lasts a or a+1 cycles, and any c consecutive periods total a·c + b cycles. Here a = `int_code` read as unsigned binary, b = `frac_num` and c = `frac_den`.
- R4: In fractional mode with b = 0, every period lasts exactly a cycles.
- R5: In integer mode (`int_mode` = 1), `frac_num` and `frac_den` are ignored (c = 0 is accepted), and every period lasts exactly a cycles. The setting is legal only when a is even and at least 6.
- R6: A load is illegal when any of the following holds:
  - fractional mode with c = 0;
  - fractional mode with b ≥ c;
  - fractional mode with a < 4;
  - integer mode with a odd or a < 6.

  An illegal load sets `cfg_err` = 1 on the cycle after `load`, and the period length in use is kept.
- R7: A legal load clears `cfg_err` to 0 on the cycle after `load`.
- R8: A legal load takes effect only at a period boundary. The period in progress when `load` is seen completes at its old length.
- R9: `tick` is high only on the first cycle of each period. `clk_out` is high for the first floor(P/2) cycles of a period of P cycles and low for the rest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_code | input | 18 | Integer part a of the ratio, unsigned binary |
| frac_num | input | 20 | Fraction numerator b |
| frac_den | input | 20 | Fraction denominator c |
| int_mode | input | 1 | 1 = integer-only mode, fraction ignored |
| load | input | 1 | Capture strobe for the four setting inputs |
| phase_ofs | input | 7 | Start delay in reference cycles, sampled during reset |
| tick | output | 1 | One-cycle pulse at the start of each output period |
| clk_out | output | 1 | Divided square-wave clock |
| cfg_err | output | 1 | Set by an illegal load, cleared by a legal one |

## Verification
Several properties are checked on every cycle:
- the period length in use is always the active integer part or one more;
- in integer mode the period length is exactly the integer part;
- the active setting is always legal and changes only at a boundary;
- the error flag moves only on a load;
- every pulse is isolated and falls in a high phase of `clk_out`.

Other behaviour can only be shown by the bench scenarios:
- that the stretched periods add up to exactly b over c periods;
- the exact start delay after reset;
- the floor(P/2) high time;
- that a period in progress keeps its old length across a load.

// File: rtl/fdiv_pkg.sv
// Package: shared widths and the setting record of the fractional divider.
// Assumes: one reference clock domain for every user of these types.
package fdiv_pkg;
    localparam int FD_INT_W        = 18;            // integer part width
    localparam int FD_FRAC_W       = 20;            // numerator / denominator width
    localparam int FD_PH_W         = 7;             // start offset width
    localparam int FD_LEN_W        = FD_INT_W + 1;  // period length incl. stretch
    localparam int FD_INT_ONLY_MIN = 6;             // smallest integer-mode ratio

    typedef struct packed {
        logic                 int_only;
        logic [FD_INT_W-1:0]  a;
        logic [FD_FRAC_W-1:0] num;
        logic [FD_FRAC_W-1:0] den;
    } fd_cfg_t;
endpackage

// File: rtl/fdiv_cfg_regs.sv
// Module: legality check, pending and active setting registers.
// A legal load is parked in the pending register and moved to the active
// register at the next period boundary. An illegal load only sets the error flag.
// Assumes: boundary is a single-cycle strobe from the period generator.
module fdiv_cfg_regs
    import fdiv_pkg::*;
#(
    parameter int DEF_RATIO    = 8,
    parameter int MIN_FRAC_INT = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  fd_cfg_t cfg_in,
    input  logic    boundary,
    output fd_cfg_t act_cfg,
    output fd_cfg_t pend_cfg,
    output logic    pend_valid,
    output logic    cfg_err
);
    localparam fd_cfg_t DEF_CFG = '{
        int_only: 1'b1,
        a:        FD_INT_W'(DEF_RATIO),
        num:      '0,
        den:      FD_FRAC_W'(1)
    };

    logic legal_int;
    logic legal_frac;
    logic legal;

    // Purpose: decide whether the presented setting may be accepted.
    always_comb begin
        legal_int  = (cfg_in.a >= FD_INT_W'(FD_INT_ONLY_MIN)) && !cfg_in.a[0];
        legal_frac = (cfg_in.den != '0) && (cfg_in.num < cfg_in.den)
                     && (cfg_in.a >= FD_INT_W'(MIN_FRAC_INT));
        legal      = cfg_in.int_only ? legal_int : legal_frac;
    end

    // Purpose: hold a legal setting until the next boundary consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_cfg   <= DEF_CFG;
            pend_valid <= 1'b0;
        end else if (load && legal) begin
            pend_cfg   <= cfg_in;
            pend_valid <= 1'b1;
        end else if (boundary) begin
            pend_valid <= 1'b0;
        end
    end

    // Purpose: switch the active setting only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cfg <= DEF_CFG;
        end else if (boundary && pend_valid) begin
            act_cfg <= pend_cfg;
        end
    end

    // Purpose: report the legality of the most recent load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else if (load) begin
            cfg_err <= !legal;
        end
    end
endmodule

// File: rtl/fdiv_dither.sv
// Module: remainder accumulator that picks a or a+1 for the next period.
// Assumes: cfg is legal (num < den in fractional mode); restart clears the
// remainder when a new setting is taken at this boundary.
module fdiv_dither
    import fdiv_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                boundary,
    input  logic                restart,
    input  fd_cfg_t             cfg,
    output logic [FD_LEN_W-1:0] next_len
);
    logic [FD_FRAC_W-1:0] acc;
    logic [FD_FRAC_W-1:0] acc_in;
    logic [FD_FRAC_W:0]   sum;
    logic                 carry;
    logic [FD_FRAC_W-1:0] acc_nx;

    // Purpose: add the numerator and stretch the period on a carry.
    always_comb begin
        acc_in   = restart ? '0 : acc;
        sum      = {1'b0, acc_in} + {1'b0, cfg.num};
        carry    = !cfg.int_only && (sum >= {1'b0, cfg.den});
        acc_nx   = cfg.int_only ? '0
                 : carry        ? FD_FRAC_W'(sum - {1'b0, cfg.den})
                 :                FD_FRAC_W'(sum);
        next_len = FD_LEN_W'(cfg.a) + FD_LEN_W'(carry);
    end

    // Purpose: keep the remainder from one period to the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (boundary) begin
            acc <= acc_nx;
        end
    end
endmodule

// File: rtl/fdiv_period_gen.sv
// Module: start delay, period counter, pulse and square-wave outputs.
// Assumes: every period length is at least 4, so floor(P/2) >= 2.
module fdiv_period_gen
    import fdiv_pkg::*;
#(
    parameter int DEF_RATIO = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FD_PH_W-1:0]  phase_ofs,
    input  logic [FD_LEN_W-1:0] next_len,
    output logic                boundary,
    output logic                tick,
    output logic                clk_out,
    output logic [FD_LEN_W-1:0] period_len
);
    logic [FD_PH_W-1:0]  ph_cnt;
    logic [FD_LEN_W-1:0] cnt;
    logic                running;

    // Purpose: derive the boundary strobe and both outputs from the counters.
    always_comb begin
        running  = (ph_cnt == '0);
        boundary = running && (cnt == period_len - FD_LEN_W'(1));
        tick     = running && (cnt == '0);
        clk_out  = running && (cnt < (period_len >> 1));
    end

    // Purpose: count out the start delay, then count reference cycles per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_cnt     <= phase_ofs;
            cnt        <= '0;
            period_len <= FD_LEN_W'(DEF_RATIO);
        end else if (!running) begin
            ph_cnt <= ph_cnt - FD_PH_W'(1);
        end else if (boundary) begin
            cnt        <= '0;
            period_len <= next_len;
        end else begin
            cnt <= cnt + FD_LEN_W'(1);
        end
    end
endmodule

// File: rtl/fdiv_top.sv
// Module: fractional clock divider top. Wires the setting registers, the
// remainder accumulator and the period generator together.
// Assumes: all inputs are synchronous to clk.
module fdiv_top
    import fdiv_pkg::*;
#(
    parameter int DEF_RATIO    = 8,
    parameter int MIN_FRAC_INT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FD_INT_W-1:0]  int_code,
    input  logic [FD_FRAC_W-1:0] frac_num,
    input  logic [FD_FRAC_W-1:0] frac_den,
    input  logic                 int_mode,
    input  logic                 load,
    input  logic [FD_PH_W-1:0]   phase_ofs,
    output logic                 tick,
    output logic                 clk_out,
    output logic                 cfg_err
);
    fd_cfg_t             cfg_in;
    fd_cfg_t             act_cfg;
    fd_cfg_t             pend_cfg;
    fd_cfg_t             sel_cfg;
    logic                pend_valid;
    logic                boundary;
    logic [FD_LEN_W-1:0] next_len;
    logic [FD_LEN_W-1:0] period_len;

    // Purpose: gather the setting inputs and choose the one for the next period.
    always_comb begin
        cfg_in  = '{int_only: int_mode, a: int_code, num: frac_num, den: frac_den};
        sel_cfg = pend_valid ? pend_cfg : act_cfg;
    end

    fdiv_cfg_regs #(
        .DEF_RATIO    (DEF_RATIO),
        .MIN_FRAC_INT (MIN_FRAC_INT)
    ) i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .cfg_in     (cfg_in),
        .boundary   (boundary),
        .act_cfg    (act_cfg),
        .pend_cfg   (pend_cfg),
        .pend_valid (pend_valid),
        .cfg_err    (cfg_err)
    );

    fdiv_dither i_dither (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .restart  (pend_valid),
        .cfg      (sel_cfg),
        .next_len (next_len)
    );

    fdiv_period_gen #(
        .DEF_RATIO (DEF_RATIO)
    ) i_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_ofs  (phase_ofs),
        .next_len   (next_len),
        .boundary   (boundary),
        .tick       (tick),
        .clk_out    (clk_out),
        .period_len (period_len)
    );
endmodule

// File: rtl/fdiv_checker.sv
// Module: cycle-by-cycle properties of the fractional divider, bound to fdiv_top.
// Assumes: synchronous active-low reset; every property is idle during reset.
module fdiv_checker
    import fdiv_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                load,
    input logic                tick,
    input logic                clk_out,
    input logic                cfg_err,
    input logic                boundary,
    input fd_cfg_t             act_cfg,
    input logic [FD_LEN_W-1:0] period_len
);
    AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (period_len == {1'b0, act_cfg.a}) || (period_len == {1'b0, act_cfg.a} + 1'b1)); // R3
    AST_INT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        act_cfg.int_only |-> (period_len == {1'b0, act_cfg.a}));                       // R5
    AST_INT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        act_cfg.int_only |-> (act_cfg.a >= FD_INT_W'(FD_INT_ONLY_MIN) && !act_cfg.a[0])); // R5
    AST_FRAC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !act_cfg.int_only |-> (act_cfg.num < act_cfg.den));                            // R6
    AST_ERR_ON_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg_err));                                                   // R6
    AST_SWITCH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(act_cfg));                                               // R8
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);                                                               // R9
    AST_TICK_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> clk_out);                                                             // R9
endmodule

bind fdiv_top fdiv_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .tick       (tick),
    .clk_out    (clk_out),
    .cfg_err    (cfg_err),
    .boundary   (boundary),
    .act_cfg    (act_cfg),
    .period_len (period_len)
);

// File: tb/test_fdiv_top.sv
// Bench: a vector table of ratios walked by one loop, then directed tests
// for reset, start offset, illegal settings and mid-period loads.
module test_fdiv_top;
    localparam time CLK_P = 10ns;

    typedef struct packed {
        logic        iom;
        logic [17:0] a;
        logic [19:0] num;
        logic [19:0] den;
        logic [7:0]  nper;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 18'd5,  20'd1, 20'd3, 8'd3},
        '{1'b0, 18'd7,  20'd2, 20'd5, 8'd5},
        '{1'b1, 18'd6,  20'd3, 20'd0, 8'd4},
        '{1'b0, 18'd10, 20'd0, 20'd7, 8'd7},
        '{1'b0, 18'd4,  20'd6, 20'd7, 8'd14},
        '{1'b1, 18'd12, 20'd5, 20'd9, 8'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] int_code = '0;
    logic [19:0] frac_num = '0;
    logic [19:0] frac_den = '0;
    logic        int_mode = 1'b0;
    logic        load = 1'b0;
    logic [6:0]  phase_ofs = '0;
    logic        tick;
    logic        clk_out;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    fdiv_top i_fdiv_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_code  (int_code),
        .frac_num  (frac_num),
        .frac_den  (frac_den),
        .int_mode  (int_mode),
        .load      (load),
        .phase_ofs (phase_ofs),
        .tick      (tick),
        .clk_out   (clk_out),
        .cfg_err   (cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_load(input bit iom, input int a, input int num, input int den);
        int_mode = iom;
        int_code = 18'(a);
        frac_num = 20'(num);
        frac_den = 20'(den);
        load     = 1'b1;
        @(negedge clk);
        load     = 1'b0;
    endtask

    task automatic sync_tick();
        @(negedge clk);
        while (!tick) @(negedge clk);
    endtask

    // Called at a negedge with tick high; returns at the next tick.
    task automatic measure(output int len, output int high);
        len  = 1;
        high = clk_out ? 1 : 0;
        @(negedge clk);
        while (!tick) begin
            len++;
            if (clk_out) high++;
            @(negedge clk);
        end
    endtask

    task automatic apply_reset(input int ofs);
        rst_n     = 1'b0;
        phase_ofs = 7'(ofs);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int len, high, n, total, lo, hi, exp_total;

        // R2: start offset of 5 cycles
        apply_reset(5);
        n = 0;
        while (!tick && n < 200) begin
            check(!clk_out, "R2 clk_out low during offset", clk_out, 0);
            @(negedge clk);
            n++;
        end
        check(n == 5, "R2 start delay", n, 5);

        // R1: reset state with zero offset and default ratio
        apply_reset(0);
        check(tick == 1'b1, "R1 tick after reset", tick, 1);
        check(clk_out == 1'b1, "R1 clk_out after reset", clk_out, 1);
        check(cfg_err == 1'b0, "R1 cfg_err after reset", cfg_err, 0);
        measure(len, high);
        check(len == 8, "R1 default period", len, 8);
        check(high == 4, "R9 default high time", high, 4);

        // R3 R4 R5 R9 R7: table of ratios
        for (int v = 0; v < NVEC; v++) begin
            do_load(VECS[v].iom, int'(VECS[v].a), int'(VECS[v].num), int'(VECS[v].den));
            check(cfg_err == 1'b0, "R7 legal load clears error", cfg_err, 0);
            sync_tick();
            sync_tick();
            lo = int'(VECS[v].a);
            hi = (VECS[v].iom || VECS[v].num == 0) ? lo : lo + 1;
            exp_total = lo * int'(VECS[v].nper)
                      + (VECS[v].iom ? 0 : int'(VECS[v].num) * int'(VECS[v].nper) / int'(VECS[v].den));
            total = 0;
            for (int p = 0; p < int'(VECS[v].nper); p++) begin
                measure(len, high);
                total += len;
                if (hi == lo)
                    check(len == lo, VECS[v].iom ? "R5 integer period exact" : "R4 zero numerator exact", len, lo);
                else
                    check(len >= lo && len <= hi, "R3 period a or a+1", len, lo);
                check(high == len / 2, "R9 high time floor(P/2)", high, len / 2);
            end
            check(total == exp_total, "R3 total over window", total, exp_total);
        end

        // R6: illegal settings keep the running ratio
        do_load(1'b1, 10, 0, 0);
        sync_tick();
        sync_tick();
        do_load(1'b0, 5, 1, 0);
        check(cfg_err == 1'b1, "R6 zero denominator", cfg_err, 1);
        do_load(1'b0, 5, 4, 4);
        check(cfg_err == 1'b1, "R6 numerator not below denominator", cfg_err, 1);
        do_load(1'b0, 3, 1, 2);
        check(cfg_err == 1'b1, "R6 fractional integer part below 4", cfg_err, 1);
        do_load(1'b1, 7, 0, 1);
        check(cfg_err == 1'b1, "R6 odd integer-mode ratio", cfg_err, 1);
        do_load(1'b1, 4, 0, 1);
        check(cfg_err == 1'b1, "R6 integer-mode ratio below 6", cfg_err, 1);
        sync_tick();
        for (int p = 0; p < 3; p++) begin
            measure(len, high);
            check(len == 10, "R6 previous ratio kept", len, 10);
        end

        // R7: a legal load clears the flag
        do_load(1'b1, 6, 0, 0);
        check(cfg_err == 1'b0, "R7 error cleared", cfg_err, 0);
        sync_tick();
        sync_tick();

        // R8: a load in mid-period leaves that period at its old length
        sync_tick();
        n = 1;
        int_mode = 1'b1;
        int_code = 18'd14;
        load     = 1'b1;
        @(negedge clk);
        load = 1'b0;
        n++;
        while (!tick && n < 100) begin
            @(negedge clk);
            if (!tick) n++;
        end
        check(n == 6, "R8 running period keeps old length", n, 6);
        measure(len, high);
        check(len == 14, "R8 new length from next period", len, 14);
        check(high == 7, "R9 high time after switch", high, 7);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule